// File: doc/BRIEF.md
# PTP Time-of-Day Counter with Accumulator Rate Trim

This block keeps a running precision-time value as an unsigned seconds count and a binary sub-second count that wraps at 2^31. A reference clock drives it, and that clock may run faster than its nominal rate. In fine mode a 32-bit addend is summed into a 32-bit phase accumulator on every clock. Only the cycles where that sum carries out add the programmed increment to the sub-second count. Software sets the addend to roughly 2^32 divided by the ratio of the actual clock to the nominal clock. This gives on average one increment per nominal period.

In the other mode the increment is added on every cycle. Apart from this steady rate, software can load an absolute time. It can also apply a one-step signed offset, made of seconds plus sub-seconds, with carry or borrow between the two fields. A new addend is staged in a shadow register and only takes effect on an update strobe. A snapshot strobe captures both fields on one edge, so software reads a consistent pair.

Top module: `ptp_time_clock`

## Requirements
- R1: After reset the live time, the snapshot and the active addend are all zero. In fine mode with no addend update, the time therefore does not move.
- R2: With `fine_mode`=1 and active addend A, the N clock edges that follow an initialise edge add the increment exactly floor(N*A/2^32) times. At each edge the increment is added only when accumulator plus addend overflows 32 bits.
- R3: An addend of 0xFFFF_FFFF gives N-1 increments in the N edges after an initialise. This is the highest rate, just below one increment per cycle.
- R4: With `fine_mode`=0 the increment is added on every edge that carries no initialise or offset request.
- R5: The sub-second field is 31 bits wide. An increment that takes it to 2^31 or above wraps it modulo 2^31 and adds one to the seconds.
- R6: `addend_wr` only loads a shadow register and has no effect on the rate. `addend_update` copies the shadow into the active addend, and the rate uses that addend from the next edge onward.
- R7: An offset request with `adj_subtract`=0 adds (`adj_sec`, `adj_subsec`) to the time. A sub-second sum of 2^31 or more carries one into the seconds.
- R8: An offset request with `adj_subtract`=1 subtracts the offset. A sub-second borrow wraps that field modulo 2^31 and takes one extra second.
- R9: `init_req` loads (`init_sec`, `init_subsec`) and clears the phase accumulator.
- R10: `snap_req` latches the live time as it was before that edge into `snap_sec`/`snap_subsec`. The latched value holds until the next `snap_req`.
- R11: Within one edge, initialise wins over an offset request, and an offset request wins over the increment. The increment due on an offset edge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fine_mode | input | 1 | 1: accumulator-gated increments; 0: increment every cycle |
| incr_value | input | INC_W | Sub-second increment per tick (nominal 43) |
| addend_wr | input | 1 | Write `addend_wdata` into the shadow addend |
| addend_wdata | input | ACC_W | New addend value |
| addend_update | input | 1 | Copy the shadow addend into the active addend |
| init_req | input | 1 | Load absolute time and clear the accumulator |
| init_sec | input | SEC_W | Seconds value to load |
| init_subsec | input | SUB_W | Sub-second value to load |
| adj_req | input | 1 | Apply a one-step offset |
| adj_subtract | input | 1 | 1: subtract offset; 0: add offset |
| adj_sec | input | SEC_W | Offset seconds |
| adj_subsec | input | SUB_W | Offset sub-seconds |
| snap_req | input | 1 | Capture the live time into the snapshot |
| time_sec | output | SEC_W | Live seconds |
| time_subsec | output | SUB_W | Live sub-seconds |
| snap_sec | output | SEC_W | Captured seconds |
| snap_subsec | output | SUB_W | Captured sub-seconds |

## Verification
The bench uses the default parameters: 32-bit seconds, a 31-bit sub-second field, a 32-bit accumulator and an 8-bit increment. Because the accumulator is full width, the real trim values are reachable in a few hundred cycles. These are the 2^32/1.32 addend for a 66 MHz clock and the saturated 0xFFFF_FFFF addend, and the exact tick counts come from floor(N*A/2^32). Loading the sub-second field a few counts below 2^31 reaches the wrap and the seconds carry in one edge. Offsets chosen near the field limit exercise both the carry and the borrow paths.

// File: rtl/ptpc_pkg.sv
// Shared definitions for the PTP time counter.
// Assumes: included first in compile order.
package ptpc_pkg;

    // Update chosen for the time registers on a given edge
    typedef enum logic [2:0] {
        UPD_HOLD    = 3'd0,
        UPD_TICK    = 3'd1,
        UPD_ADJ_ADD = 3'd2,
        UPD_ADJ_SUB = 3'd3,
        UPD_LOAD    = 3'd4
    } upd_sel_e;

endpackage

// File: rtl/ptpc_rate_gen.sv
// Rate generator: shadow/active addend registers and a phase accumulator.
// In fine mode a tick is issued on each accumulator carry-out; otherwise a
// tick is issued every cycle. A shadow write and an update in the same cycle
// move the old shadow value into the active addend.
module ptpc_rate_gen #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fine_mode,
    input  logic             clear_acc,
    input  logic             addend_wr,
    input  logic [ACC_W-1:0] addend_wdata,
    input  logic             addend_update,
    output logic             tick_o
);

    logic [ACC_W-1:0] shadow_q;
    logic [ACC_W-1:0] addend_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   acc_sum;

    // Sum with carry out of the accumulator stage
    always_comb begin
        acc_sum = {1'b0, acc_q} + {1'b0, addend_q};
        tick_o  = fine_mode ? acc_sum[ACC_W] : 1'b1;
    end

    // Addend staging and accumulator update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            addend_q <= '0;
            acc_q    <= '0;
        end else begin
            if (addend_wr)     shadow_q <= addend_wdata;
            if (addend_update) addend_q <= shadow_q;
            if (clear_acc)     acc_q    <= '0;
            else if (fine_mode) acc_q   <= acc_sum[ACC_W-1:0];
        end
    end

    // R6
    addend_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addend_update |=> $stable(addend_q));

    // R9
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_acc |=> (acc_q == '0));

endmodule

// File: rtl/ptpc_time_core.sv
// Time registers: seconds plus a binary sub-second field wrapping at 2^SUB_W.
// Priority per edge: load, then offset, then tick (a tick on an offset edge
// is dropped). Assumes incr_i < 2^SUB_W and INC_W <= SUB_W.
module ptpc_time_core
    import ptpc_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int SUB_W = 31,
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [INC_W-1:0] incr_i,
    input  logic             init_i,
    input  logic [SEC_W-1:0] init_sec_i,
    input  logic [SUB_W-1:0] init_sub_i,
    input  logic             adj_i,
    input  logic             adj_subtract_i,
    input  logic [SEC_W-1:0] adj_sec_i,
    input  logic [SUB_W-1:0] adj_sub_i,
    output logic [SEC_W-1:0] sec_o,
    output logic [SUB_W-1:0] sub_o
);

    localparam int PAD_W = SUB_W + 1 - INC_W;

    logic [SEC_W-1:0] sec_q;
    logic [SUB_W-1:0] sub_q;
    logic [SUB_W:0]   inc_sum;
    logic [SUB_W:0]   add_sum;
    logic [SUB_W:0]   sub_diff;
    upd_sel_e         sel;

    // Candidate sub-second results and their carry/borrow bits
    always_comb begin
        inc_sum  = {1'b0, sub_q} + {{PAD_W{1'b0}}, incr_i};
        add_sum  = {1'b0, sub_q} + {1'b0, adj_sub_i};
        sub_diff = {1'b0, sub_q} - {1'b0, adj_sub_i};
    end

    // Priority select of this edge's update
    always_comb begin
        if (init_i)      sel = UPD_LOAD;
        else if (adj_i)  sel = adj_subtract_i ? UPD_ADJ_SUB : UPD_ADJ_ADD;
        else if (tick_i) sel = UPD_TICK;
        else             sel = UPD_HOLD;
    end

    // Time register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            sub_q <= '0;
        end else begin
            case (sel)
                UPD_LOAD: begin
                    sec_q <= init_sec_i;
                    sub_q <= init_sub_i;
                end
                UPD_ADJ_ADD: begin
                    sec_q <= sec_q + adj_sec_i + {{(SEC_W-1){1'b0}}, add_sum[SUB_W]};
                    sub_q <= add_sum[SUB_W-1:0];
                end
                UPD_ADJ_SUB: begin
                    sec_q <= sec_q - adj_sec_i - {{(SEC_W-1){1'b0}}, sub_diff[SUB_W]};
                    sub_q <= sub_diff[SUB_W-1:0];
                end
                UPD_TICK: begin
                    sec_q <= sec_q + {{(SEC_W-1){1'b0}}, inc_sum[SUB_W]};
                    sub_q <= inc_sum[SUB_W-1:0];
                end
                default: ;
            endcase
        end
    end

    assign sec_o = sec_q;
    assign sub_o = sub_q;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !init_i && !adj_i) |=> ($stable(sec_q) && $stable(sub_q)));

    // R5
    tick_sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !init_i && !adj_i) |=>
            ((sec_q == $past(sec_q)) || (sec_q == $past(sec_q) + 1'b1)));

    // R9
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> ((sec_q == $past(init_sec_i)) && (sub_q == $past(init_sub_i))));

endmodule

// File: rtl/ptpc_snapshot.sv
// Snapshot register: captures seconds and sub-seconds together on one edge.
// Assumes the inputs are the registered live time.
module ptpc_snapshot #(
    parameter int SEC_W = 32,
    parameter int SUB_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snap_i,
    input  logic [SEC_W-1:0] sec_i,
    input  logic [SUB_W-1:0] sub_i,
    output logic [SEC_W-1:0] snap_sec_o,
    output logic [SUB_W-1:0] snap_sub_o
);

    // Coherent capture of both fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_sec_o <= '0;
            snap_sub_o <= '0;
        end else if (snap_i) begin
            snap_sec_o <= sec_i;
            snap_sub_o <= sub_i;
        end
    end

    // R10
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_i |=> ($stable(snap_sec_o) && $stable(snap_sub_o)));

endmodule

// File: rtl/ptp_time_clock.sv
// Top: PTP time counter with accumulator-based rate trim, one-step offset,
// absolute load and coherent snapshot. All strobes are single-cycle pulses
// synchronous to clk.
module ptp_time_clock #(
    parameter int SEC_W = 32,
    parameter int SUB_W = 31,
    parameter int ACC_W = 32,
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fine_mode,
    input  logic [INC_W-1:0] incr_value,
    input  logic             addend_wr,
    input  logic [ACC_W-1:0] addend_wdata,
    input  logic             addend_update,
    input  logic             init_req,
    input  logic [SEC_W-1:0] init_sec,
    input  logic [SUB_W-1:0] init_subsec,
    input  logic             adj_req,
    input  logic             adj_subtract,
    input  logic [SEC_W-1:0] adj_sec,
    input  logic [SUB_W-1:0] adj_subsec,
    input  logic             snap_req,
    output logic [SEC_W-1:0] time_sec,
    output logic [SUB_W-1:0] time_subsec,
    output logic [SEC_W-1:0] snap_sec,
    output logic [SUB_W-1:0] snap_subsec
);

    logic tick;

    ptpc_rate_gen #(.ACC_W(ACC_W)) u_rate (
        .clk           (clk),
        .rst_n         (rst_n),
        .fine_mode     (fine_mode),
        .clear_acc     (init_req),
        .addend_wr     (addend_wr),
        .addend_wdata  (addend_wdata),
        .addend_update (addend_update),
        .tick_o        (tick)
    );

    ptpc_time_core #(.SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W)) u_core (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (tick),
        .incr_i         (incr_value),
        .init_i         (init_req),
        .init_sec_i     (init_sec),
        .init_sub_i     (init_subsec),
        .adj_i          (adj_req),
        .adj_subtract_i (adj_subtract),
        .adj_sec_i      (adj_sec),
        .adj_sub_i      (adj_subsec),
        .sec_o          (time_sec),
        .sub_o          (time_subsec)
    );

    ptpc_snapshot #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_snap (
        .clk        (clk),
        .rst_n      (rst_n),
        .snap_i     (snap_req),
        .sec_i      (time_sec),
        .sub_i      (time_subsec),
        .snap_sec_o (snap_sec),
        .snap_sub_o (snap_subsec)
    );

endmodule

// File: tb/tb_ptp_time_clock.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_ptp_time_clock;

    localparam int CLK_PERIOD = 10;
    localparam int SEC_W = 32;
    localparam int SUB_W = 31;
    localparam int ACC_W = 32;
    localparam int INC_W = 8;
    localparam int INC   = 43;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             fine_mode;
    logic [INC_W-1:0] incr_value;
    logic             addend_wr;
    logic [ACC_W-1:0] addend_wdata;
    logic             addend_update;
    logic             init_req;
    logic [SEC_W-1:0] init_sec;
    logic [SUB_W-1:0] init_subsec;
    logic             adj_req;
    logic             adj_subtract;
    logic [SEC_W-1:0] adj_sec;
    logic [SUB_W-1:0] adj_subsec;
    logic             snap_req;
    logic [SEC_W-1:0] time_sec;
    logic [SUB_W-1:0] time_subsec;
    logic [SEC_W-1:0] snap_sec;
    logic [SUB_W-1:0] snap_subsec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptp_time_clock #(.SEC_W(SEC_W), .SUB_W(SUB_W), .ACC_W(ACC_W), .INC_W(INC_W)) dut (
        .clk(clk), .rst_n(rst_n), .fine_mode(fine_mode), .incr_value(incr_value),
        .addend_wr(addend_wr), .addend_wdata(addend_wdata), .addend_update(addend_update),
        .init_req(init_req), .init_sec(init_sec), .init_subsec(init_subsec),
        .adj_req(adj_req), .adj_subtract(adj_subtract), .adj_sec(adj_sec),
        .adj_subsec(adj_subsec), .snap_req(snap_req), .time_sec(time_sec),
        .time_subsec(time_subsec), .snap_sec(snap_sec), .snap_subsec(snap_subsec)
    );

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic check_time(input string req, input longint es, input longint esub);
        checks++;
        if (time_sec !== SEC_W'(es) || time_subsec !== SUB_W'(esub)) begin
            errors++;
            $display("FAIL %s: time actual %0d.%0d expected %0d.%0d",
                     req, time_sec, time_subsec, es, esub);
        end
    endtask

    task automatic check_snap(input string req, input longint es, input longint esub);
        checks++;
        if (snap_sec !== SEC_W'(es) || snap_subsec !== SUB_W'(esub)) begin
            errors++;
            $display("FAIL %s: snapshot actual %0d.%0d expected %0d.%0d",
                     req, snap_sec, snap_subsec, es, esub);
        end
    endtask

    // Expected time after 'ticks' increments from a loaded value
    task automatic check_ticks(input string req, input longint s0, input longint sub0,
                               input longint ticks);
        longint total;
        total = sub0 + ticks * INC;
        check_time(req, s0 + (total >> SUB_W), total & ((64'd1 << SUB_W) - 1));
    endtask

    task automatic set_addend(input longint a, input bit commit);
        addend_wdata = ACC_W'(a);
        addend_wr = 1'b1;
        cycle();
        addend_wr = 1'b0;
        if (commit) begin
            addend_update = 1'b1;
            cycle();
            addend_update = 1'b0;
        end
    endtask

    task automatic load_time(input longint s, input longint sub);
        init_sec = SEC_W'(s);
        init_subsec = SUB_W'(sub);
        init_req = 1'b1;
        cycle();
        init_req = 1'b0;
    endtask

    task automatic offset(input bit neg, input longint s, input longint sub);
        adj_subtract = neg;
        adj_sec = SEC_W'(s);
        adj_subsec = SUB_W'(sub);
        adj_req = 1'b1;
        cycle();
        adj_req = 1'b0;
    endtask

    task automatic t_reset();
        check_time("R1", 0, 0);
        check_snap("R1", 0, 0);
        fine_mode = 1'b1;
        run(10);
        check_time("R1", 0, 0);
    endtask

    task automatic t_shadow();
        fine_mode = 1'b1;
        set_addend(64'h8000_0000, 1'b0);
        load_time(1, 0);
        run(20);
        check_time("R6", 1, 0);
        addend_update = 1'b1;
        cycle();
        addend_update = 1'b0;
        load_time(1, 0);
        run(20);
        check_ticks("R6", 1, 0, 10);
    endtask

    task automatic t_fine();
        longint a;
        fine_mode = 1'b1;
        a = 64'd3253763103;
        set_addend(a, 1'b1);
        load_time(2, 100);
        run(132);
        check_ticks("R2", 2, 100, (132 * a) >> 32);
        set_addend(64'h4000_0000, 1'b1);
        load_time(2, 0);
        run(37);
        check_ticks("R2", 2, 0, 9);
    endtask

    task automatic t_max();
        fine_mode = 1'b1;
        set_addend(64'hFFFF_FFFF, 1'b1);
        load_time(0, 5);
        run(50);
        check_ticks("R3", 0, 5, 49);
    endtask

    task automatic t_every_cycle();
        fine_mode = 1'b0;
        load_time(3, 0);
        run(25);
        check_ticks("R4", 3, 0, 25);
    endtask

    task automatic t_rollover();
        fine_mode = 1'b0;
        load_time(5, 64'h7FFF_FFF0);
        run(1);
        check_time("R5", 6, 27);
        load_time(5, 64'h7FFF_FFD5);
        run(1);
        check_time("R5", 6, 0);
    endtask

    task automatic t_offsets();
        fine_mode = 1'b1;
        set_addend(0, 1'b1);
        load_time(10, 64'h7FFF_FF00);
        offset(1'b0, 3, 64'h200);
        check_time("R7", 14, 64'h100);
        offset(1'b1, 2, 64'h200);
        check_time("R8", 11, 64'h7FFF_FF00);
        offset(1'b1, 1, 64'h7FFF_FF00);
        check_time("R8", 10, 0);
    endtask

    task automatic t_acc_clear();
        fine_mode = 1'b1;
        set_addend(64'h8000_0000, 1'b1);
        load_time(4, 0);
        run(1);
        load_time(4, 0);
        run(1);
        check_time("R9", 4, 0);
        run(1);
        check_time("R9", 4, INC);
    endtask

    task automatic t_priority();
        fine_mode = 1'b0;
        load_time(7, 0);
        offset(1'b0, 1, 0);
        check_time("R11", 8, 0);
        run(2);
        check_time("R11", 8, 2 * INC);
        init_sec = 30;
        init_subsec = 9;
        adj_subtract = 1'b0;
        adj_sec = 5;
        adj_subsec = 5;
        init_req = 1'b1;
        adj_req = 1'b1;
        cycle();
        init_req = 1'b0;
        adj_req = 1'b0;
        check_time("R11", 30, 9);
    endtask

    task automatic t_snapshot();
        fine_mode = 1'b0;
        load_time(20, 64'h7FFF_FFD5);
        run(1);
        snap_req = 1'b1;
        cycle();
        snap_req = 1'b0;
        run(5);
        check_snap("R10", 21, 0);
        check_time("R10", 21, 6 * INC);
        snap_req = 1'b1;
        cycle();
        snap_req = 1'b0;
        check_snap("R10", 21, 6 * INC);
    endtask

    initial begin
        rst_n = 1'b0;
        fine_mode = 1'b1;
        incr_value = INC_W'(INC);
        addend_wr = 1'b0;
        addend_wdata = '0;
        addend_update = 1'b0;
        init_req = 1'b0;
        init_sec = '0;
        init_subsec = '0;
        adj_req = 1'b0;
        adj_subtract = 1'b0;
        adj_sec = '0;
        adj_subsec = '0;
        snap_req = 1'b0;
        run(3);
        rst_n = 1'b1;
        t_reset();
        t_shadow();
        t_fine();
        t_max();
        t_every_cycle();
        t_rollover();
        t_offsets();
        t_acc_clear();
        t_priority();
        t_snapshot();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule